// File: doc/BRIEF.md
# GPIO interrupt cause and mask unit

This unit turns a bank's polarity-adjusted input vector into grouped interrupt requests for a top-level interrupt controller. Each line can raise a request in two ways. A rising transition of the adjusted input latches a sticky bit in the edge cause register. Alternatively, the adjusted input can be used directly as a level source. The edge mask and level mask registers choose which of these two sources reaches the outputs, and each CPU has its own pair of masks. Requests are ORed in groups of eight consecutive lines, so each CPU receives one output per group. Software acknowledges an edge by writing the cause register with a zero in the bits it wants to clear and ones everywhere else.

Software reaches the registers over a simple single-cycle write port with a combinational read port. The first CPU's masks sit next to the cause register. Every further CPU's pair sits in a separate window at a parameterized base and stride. The outputs are registered, so a change in cause, mask or level input shows up on them one clock later.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset the cause register and every mask register read as zero, and all interrupt outputs are low.
- R2: A 0-to-1 change of an adjusted input bit between two consecutive clock edges sets the matching cause bit at the second edge. The input level present when reset is released does not count as a change.
- R3: An adjusted input bit that stays high, or that falls from 1 to 0, sets no cause bit.
- R4: A write to the cause register at offset 0x14 clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R5: When a new edge on a line arrives in the same cycle as a write that clears that line's cause bit, the bit stays set.
- R6: A line's level request is its adjusted input ANDed with its level mask bit, with no latching. The request drops as soon as the input drops.
- R7: A CPU's pending vector is (input AND level mask) OR (cause AND edge mask). Output group g of that CPU is the OR of pending bits 8g to 8g+7.
- R8: Output bit index c*4+g belongs to CPU c and group g, and CPU c's outputs depend only on CPU c's own masks.
- R9: The mask offsets are as follows: CPU 0 edge mask at 0x18, CPU 0 level mask at 0x1C, CPU 1 edge mask at 0x30, CPU 1 level mask at 0x34. Reads return the register contents. Reads of any other offset return 0, and writes to any other offset change nothing.
- R10: Outputs are registered. A level request appears one clock after the input change. An edge request appears one clock after its cause bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_adj | input | NUM_LINES | Polarity-adjusted input vector from the bank |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | NUM_LINES | Write data |
| bus_rdata | output | NUM_LINES | Combinational read data for bus_addr |
| irq | output | NUM_CPUS*NUM_GROUPS | Registered group requests, bit c*NUM_GROUPS+g |

## Verification
The bench uses the default build: 32 lines, groups of eight and two CPUs, which gives eight outputs and both mask windows. Every one of the 32 lines is swept against each CPU in turn. This covers every line-to-group and CPU-to-output mapping. It also tests the edge, clear, clear-during-edge and level paths on each line. Because the bench drives the other CPU's masks to zero in each step, it can show that a CPU's outputs respond only to that CPU's masks.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Distance from a CPU's edge mask to its level mask inside the extra windows.
    localparam int LEVEL_GAP = 4;

    function automatic int edge_mask_ofs(int cpu, int ofs0, int xbase, int stride);
        return (cpu == 0) ? ofs0 : xbase + (cpu - 1) * stride;
    endfunction

    function automatic int level_mask_ofs(int cpu, int ofs0, int xbase, int stride);
        return (cpu == 0) ? ofs0 : xbase + (cpu - 1) * stride + LEVEL_GAP;
    endfunction

endpackage

// File: rtl/gpio_irq_cause.sv
module gpio_irq_cause #(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 8,
    parameter int CAUSE_OFS = 'h14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pin_adj,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] cause
);

    typedef struct packed {
        logic                 primed;
        logic [NUM_LINES-1:0] prev;
        logic [NUM_LINES-1:0] cause;
    } state_t;

    state_t s_d, s_q;
    logic [NUM_LINES-1:0] rise;
    logic [NUM_LINES-1:0] keep;
    logic                 cause_wr;

    always_comb begin
        cause_wr   = bus_we && (bus_addr == ADDR_W'(CAUSE_OFS));
        rise       = s_q.primed ? (pin_adj & ~s_q.prev) : '0;
        keep       = cause_wr ? bus_wdata : '1;
        s_d        = s_q;
        s_d.primed = 1'b1;
        s_d.prev   = pin_adj;
        // A fresh edge overrides a clearing write in the same cycle.
        s_d.cause  = (s_q.cause & keep) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cause = s_q.cause;

    assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((s_q.cause & $past(rise)) == $past(rise)));

    assert_write_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_wr && rise == '0) |=> (s_q.cause == ($past(s_q.cause) & $past(bus_wdata))));

endmodule

// File: rtl/gpio_irq_masks.sv
module gpio_irq_masks
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES   = 32,
    parameter int NUM_CPUS    = 2,
    parameter int ADDR_W      = 8,
    parameter int EDGE0_OFS   = 'h18,
    parameter int LEVEL0_OFS  = 'h1C,
    parameter int XCPU_BASE   = 'h30,
    parameter int XCPU_STRIDE = 'h08
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bus_we,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic [NUM_LINES-1:0]                bus_wdata,
    output logic [NUM_CPUS-1:0][NUM_LINES-1:0]  edge_mask,
    output logic [NUM_CPUS-1:0][NUM_LINES-1:0]  level_mask
);

    typedef struct packed {
        logic [NUM_CPUS-1:0][NUM_LINES-1:0] edge_m;
        logic [NUM_CPUS-1:0][NUM_LINES-1:0] level_m;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int c = 0; c < NUM_CPUS; c++) begin
            if (bus_we && bus_addr == ADDR_W'(edge_mask_ofs(c, EDGE0_OFS, XCPU_BASE, XCPU_STRIDE)))
                s_d.edge_m[c] = bus_wdata;
            if (bus_we && bus_addr == ADDR_W'(level_mask_ofs(c, LEVEL0_OFS, XCPU_BASE, XCPU_STRIDE)))
                s_d.level_m[c] = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign edge_mask  = s_q.edge_m;
    assign level_mask = s_q.level_m;

    assert_masks_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(s_q));

endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route #(
    parameter int NUM_LINES = 32,
    parameter int NUM_CPUS  = 2,
    parameter int GROUP_W   = 8,
    localparam int NUM_GROUPS = (NUM_LINES + GROUP_W - 1) / GROUP_W,
    localparam int PAD_W      = NUM_GROUPS * GROUP_W,
    localparam int IRQ_W      = NUM_CPUS * NUM_GROUPS
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_LINES-1:0]                pin_adj,
    input  logic [NUM_LINES-1:0]                cause,
    input  logic [NUM_CPUS-1:0][NUM_LINES-1:0]  edge_mask,
    input  logic [NUM_CPUS-1:0][NUM_LINES-1:0]  level_mask,
    output logic [IRQ_W-1:0]                    irq
);

    typedef struct packed {
        logic [IRQ_W-1:0] irq;
    } state_t;

    state_t s_d, s_q;
    logic [NUM_CPUS-1:0][PAD_W-1:0] pend;

    always_comb begin
        s_d = s_q;
        for (int c = 0; c < NUM_CPUS; c++) begin
            pend[c] = PAD_W'((pin_adj & level_mask[c]) | (cause & edge_mask[c]));
            for (int g = 0; g < NUM_GROUPS; g++)
                s_d.irq[c*NUM_GROUPS + g] = |pend[c][g*GROUP_W +: GROUP_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq = s_q.irq;

    for (genvar gc = 0; gc < NUM_CPUS; gc++) begin : g_cpu_chk
        assert_quiet_cpu_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_mask[gc] == '0 && level_mask[gc] == '0)
                |=> (s_q.irq[gc*NUM_GROUPS +: NUM_GROUPS] == '0));
    end

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES   = 32,
    parameter int NUM_CPUS    = 2,
    parameter int GROUP_W     = 8,
    parameter int ADDR_W      = 8,
    parameter int CAUSE_OFS   = 'h14,
    parameter int EDGE0_OFS   = 'h18,
    parameter int LEVEL0_OFS  = 'h1C,
    parameter int XCPU_BASE   = 'h30,
    parameter int XCPU_STRIDE = 'h08,
    localparam int NUM_GROUPS = (NUM_LINES + GROUP_W - 1) / GROUP_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_LINES-1:0]           pin_adj,
    input  logic                           bus_we,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [NUM_LINES-1:0]           bus_wdata,
    output logic [NUM_LINES-1:0]           bus_rdata,
    output logic [NUM_CPUS*NUM_GROUPS-1:0] irq
);

    logic [NUM_LINES-1:0]               cause;
    logic [NUM_CPUS-1:0][NUM_LINES-1:0] edge_mask;
    logic [NUM_CPUS-1:0][NUM_LINES-1:0] level_mask;

    gpio_irq_cause #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W),
        .CAUSE_OFS (CAUSE_OFS)
    ) i_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_adj   (pin_adj),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cause     (cause)
    );

    gpio_irq_masks #(
        .NUM_LINES   (NUM_LINES),
        .NUM_CPUS    (NUM_CPUS),
        .ADDR_W      (ADDR_W),
        .EDGE0_OFS   (EDGE0_OFS),
        .LEVEL0_OFS  (LEVEL0_OFS),
        .XCPU_BASE   (XCPU_BASE),
        .XCPU_STRIDE (XCPU_STRIDE)
    ) i_masks (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .edge_mask  (edge_mask),
        .level_mask (level_mask)
    );

    gpio_irq_route #(
        .NUM_LINES (NUM_LINES),
        .NUM_CPUS  (NUM_CPUS),
        .GROUP_W   (GROUP_W)
    ) i_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_adj    (pin_adj),
        .cause      (cause),
        .edge_mask  (edge_mask),
        .level_mask (level_mask),
        .irq        (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CAUSE_OFS))
            bus_rdata = cause;
        for (int c = 0; c < NUM_CPUS; c++) begin
            if (bus_addr == ADDR_W'(edge_mask_ofs(c, EDGE0_OFS, XCPU_BASE, XCPU_STRIDE)))
                bus_rdata = edge_mask[c];
            if (bus_addr == ADDR_W'(level_mask_ofs(c, LEVEL0_OFS, XCPU_BASE, XCPU_STRIDE)))
                bus_rdata = level_mask[c];
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (irq == '0 && cause == '0));

endmodule

// File: tb/test_gpio_irq_unit.sv
module test_gpio_irq_unit;

    localparam int N  = 32;
    localparam int C  = 2;
    localparam int G  = 8;
    localparam int NG = N / G;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pin_adj = '0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_addr = 8'h00;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic [C*NG-1:0] irq;

    int total = 0;
    int bad   = 0;

    gpio_irq_unit i_gpio_irq_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_adj   (pin_adj),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #10 clk = ~clk;

    localparam logic [7:0] A_CAUSE = 8'h14;

    function automatic logic [7:0] a_edge(int c);
        return (c == 0) ? 8'h18 : 8'h30;
    endfunction

    function automatic logic [7:0] a_level(int c);
        return (c == 0) ? 8'h1C : 8'h34;
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        tick();
        bus_we    = 1'b0;
        bus_addr  = 8'h00;
    endtask

    task automatic rd(input logic [7:0] a, output logic [N-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 8'h00;
    endtask

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_reg(input string req, input logic [7:0] a, input logic [N-1:0] exp);
        logic [N-1:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [N-1:0] bit_v;
        logic [N-1:0] exp_irq;

        pin_adj = 32'hF0F0_0000;
        repeat (3) tick();
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 irq", N'(irq), '0);
        chk_reg("R1 cause", A_CAUSE, '0);
        for (int c = 0; c < C; c++) begin
            chk_reg("R1 edge mask", a_edge(c), '0);
            chk_reg("R1 level mask", a_level(c), '0);
        end
        // R2: level present at reset release is not an edge
        repeat (3) tick();
        chk_reg("R2 no startup edge", A_CAUSE, '0);
        pin_adj = '0;
        tick();
        chk_reg("R3 falling sets nothing", A_CAUSE, '0);

        // R9: unmapped offset ignored and reads zero
        wr(8'h20, '1);
        wr(8'h10, '1);
        chk_reg("R9 unmapped read", 8'h20, '0);
        chk_reg("R9 cause untouched", A_CAUSE, '0);
        for (int c = 0; c < C; c++) begin
            chk_reg("R9 edge untouched", a_edge(c), '0);
            chk_reg("R9 level untouched", a_level(c), '0);
        end

        for (int c = 0; c < C; c++) begin
            for (int i = 0; i < N; i++) begin
                bit_v   = N'(1) << i;
                exp_irq = N'(1) << (c * NG + i / G);
                wr(a_edge(0), (c == 0) ? bit_v : '0);
                wr(a_edge(1), (c == 1) ? bit_v : '0);
                wr(a_level(0), '0);
                wr(a_level(1), '0);
                chk_reg("R9 edge readback", a_edge(c), bit_v);

                // Edge path
                pin_adj = bit_v;
                tick();
                chk_reg("R2 edge latched", A_CAUSE, bit_v);
                chk("R10 edge irq not yet", N'(irq), '0);
                tick();
                chk("R7 R8 edge irq group", N'(irq), exp_irq);
                wr(A_CAUSE, ~bit_v);
                chk_reg("R4 cleared by zero", A_CAUSE, '0);
                chk_reg("R3 held high no edge", A_CAUSE, '0);
                tick();
                chk("R7 irq drops after clear", N'(irq), '0);
                pin_adj = '0;
                tick();
                chk_reg("R3 falling no edge", A_CAUSE, '0);

                // Edge coincides with clearing write
                bus_addr  = A_CAUSE;
                bus_wdata = ~bit_v;
                bus_we    = 1'b1;
                pin_adj   = bit_v;
                tick();
                bus_we    = 1'b0;
                bus_addr  = 8'h00;
                chk_reg("R5 edge wins over clear", A_CAUSE, bit_v);
                wr(A_CAUSE, '0);
                pin_adj = '0;
                tick();

                // Level path
                wr(a_edge(c), '0);
                wr(a_level(c), bit_v);
                chk_reg("R9 level readback", a_level(c), bit_v);
                pin_adj = bit_v;
                #1;
                chk("R10 level irq not yet", N'(irq), '0);
                tick();
                chk("R6 R8 level irq", N'(irq), exp_irq);
                pin_adj = '0;
                tick();
                chk("R6 level not latched", N'(irq), '0);
                wr(A_CAUSE, '0);
                wr(a_level(c), '0);
            end
        end

        // R4: ones keep their bits
        pin_adj = '1;
        tick();
        chk_reg("R2 all lines latched", A_CAUSE, '1);
        wr(A_CAUSE, 32'h0F0F_0F0F);
        chk_reg("R4 ones keep", A_CAUSE, 32'h0F0F_0F0F);
        // R8: CPU 0 mask only
        wr(a_edge(0), 32'h0000_0F00);
        tick();
        chk("R8 only cpu0 group1", N'(irq), N'(8'b0000_0010));
        wr(a_edge(0), '0);
        wr(A_CAUSE, '0);
        pin_adj = '0;
        tick();
        chk("R7 all quiet", N'(irq), '0);

        finish_run();
    end

endmodule